// File: doc/BRIEF.md
# Endpoint DMA Handshake Controller

This block sits between an external DMA master and the endpoint buffers of a full-speed USB peripheral. Software picks one endpoint as the DMA target through a configuration write. The block then raises a request whenever that endpoint has data to give or room to take. It counts the bytes the master acknowledges and drops the request at the end of each single-cycle or burst transfer. A transfer ends when a terminal count is reached, when the external end-of-transfer pin goes active, or when the packet engine reports a short or empty packet.

The block also steers the shared data port. While the acknowledge pin is active, the port addresses the DMA target endpoint. At all other times it addresses the endpoint held in the I/O-mode pointer. DMA cycles and ordinary register accesses to other endpoints can therefore interleave, and the pointer is left as it was. The transfer direction is never programmed here. It comes from the selected endpoint's direction bit.

The controller is a three-state machine. IDLE (DMA off) moves to ARM when the enable is set. ARM (waiting) moves to REQ when the target is valid and ready. REQ (request active) returns to ARM on the last byte of a burst. ARM and REQ both return to IDLE on any end-of-transfer event or when the enable is cleared. A configuration write forces ARM if it sets the enable and IDLE otherwise.

Top module: `epdma_hs_ctrl`

## Requirements
- R1: After reset, dreq_pin is 0, dma_en is 0, eot_flag is 0, xfer_left is 0, port_dma is 0 and port_ep is 0. All three pin polarities reset to active-high.
- R2: The request becomes active in the second cycle after a configuration write that sets the enable, and only when ep_valid and ep_ready are both 1 at the selected index. An index whose ep_valid bit is 0 keeps the request inactive.
- R3: dma_dir equals ep_dir at the selected index. With dma_dir 0 (OUT endpoint), an acknowledged byte pulses buf_rd. With dma_dir 1 (IN endpoint), it pulses buf_wr.
- R4: While the acknowledge is active, port_ep is the configured DMA endpoint and port_dma is 1. Otherwise port_ep is the I/O pointer, port_dma is 0, and io_rd and io_wr pass to buf_rd and buf_wr. The I/O pointer changes only when io_ptr_we is 1.
- R5: In single mode (cfg_burst 0) the request is inactive in the cycle after each acknowledged byte. In burst mode a burst is cfg_blen+1 bytes, from 1 to 16, and the request drops in the cycle after the last byte of the burst.
- R6: With cfg_dack_only 0 (strobe-qualified mode), a byte counts only when the acknowledge is active together with io_rd for a read or io_wr for a write. With cfg_dack_only 1, every clock with the acknowledge active in the request state counts as a byte.
- R7: xfer_left is loaded by a configuration write and goes down by one for each acknowledged byte. When it reaches zero, dma_en clears, eot_flag sets and the request is inactive in the next cycle.
- R8: The external end-of-transfer pin at its active level, while enabled, ends the transfer. dma_en clears and eot_flag sets in the next cycle.
- R9: A short_pkt pulse while enabled ends the transfer in the same way as R8.
- R10: A polarity bit of 1 makes its pin active-high and 0 makes it active-low. There is one bit each for the request, the acknowledge and the end-of-transfer pin.
- R11: eot_flag stays at 1 until an eot_clr pulse. When a new end event arrives in the same cycle as the clear, the flag stays set.
- R12: Loading a count of 0 with the enable set raises a terminal-count end in the next cycle and never raises the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_ep | input | 4 | Target endpoint index |
| cfg_burst | input | 1 | 1 = burst mode, 0 = single-cycle |
| cfg_blen | input | 4 | Burst length minus one |
| cfg_cnt | input | 16 | Transfer byte count |
| cfg_en | input | 1 | DMA enable |
| cfg_dack_only | input | 1 | 1 = acknowledge-only handshake, 0 = strobe-qualified |
| cfg_dreq_pol | input | 1 | Request pin polarity (1 = active-high) |
| cfg_dack_pol | input | 1 | Acknowledge pin polarity (1 = active-high) |
| cfg_eot_pol | input | 1 | End-of-transfer pin polarity (1 = active-high) |
| eot_clr | input | 1 | Clears the sticky end flag |
| io_ptr_we | input | 1 | I/O pointer write strobe |
| io_ptr_d | input | 4 | New I/O pointer value |
| io_rd | input | 1 | Bus read strobe |
| io_wr | input | 1 | Bus write strobe |
| ep_valid | input | 16 | Per-index flag: endpoint is configured |
| ep_dir | input | 16 | Per-index direction bit (1 = IN) |
| ep_ready | input | 16 | Per-index flag: data available or space free |
| short_pkt | input | 1 | Short or empty packet seen on the target |
| dack_pin | input | 1 | DMA acknowledge pin |
| eot_pin | input | 1 | External end-of-transfer pin |
| dreq_pin | output | 1 | DMA request pin |
| port_ep | output | 4 | Endpoint addressed by the data port |
| port_dma | output | 1 | Data port is in a DMA cycle |
| buf_rd | output | 1 | Buffer read strobe |
| buf_wr | output | 1 | Buffer write strobe |
| dma_dir | output | 1 | Current DMA direction |
| dma_en | output | 1 | DMA enable state |
| eot_flag | output | 1 | Sticky end-of-transfer flag |
| xfer_left | output | 16 | Bytes remaining |

## Verification
The bench uses the default parameters: a 4-bit endpoint index, a 16-bit byte counter and a 4-bit burst-length field. The index space of 16 is larger than the 14 configured endpoints, so the bench can select an index whose valid bit is 0. The 4-bit burst field allows four-byte and sixteen-byte bursts. The 16-bit counter lets the bench load small counts such as 3 and also 0, which puts the terminal-count and zero-load cases within a few cycles.

// File: rtl/epdma_pkg.sv
package epdma_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_ARM  = 2'd1,
        ST_REQ  = 2'd2
    } dma_state_e;

endpackage

// File: rtl/epdma_fsm.sv
module epdma_fsm
    import epdma_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cfg_load,
    input  logic       cfg_en,
    input  logic       en_q,
    input  logic       ep_ok,
    input  logic       eot_evt,
    input  logic       byte_ok,
    input  logic       burst_done,
    output dma_state_e state_q,
    output logic       dreq_act,
    output logic       in_req
);

    dma_state_e state_d;

    always_comb begin
        state_d = state_q;
        if (cfg_load) begin
            state_d = cfg_en ? ST_ARM : ST_IDLE;
        end else begin
            unique case (state_q)
                ST_IDLE: if (en_q && !eot_evt) state_d = ST_ARM;
                ST_ARM: begin
                    if (!en_q || eot_evt) state_d = ST_IDLE;
                    else if (ep_ok)       state_d = ST_REQ;
                end
                ST_REQ: begin
                    if (!en_q || eot_evt)          state_d = ST_IDLE;
                    else if (byte_ok && burst_done) state_d = ST_ARM;
                end
                default: state_d = ST_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        dreq_act = (state_q == ST_REQ);
        in_req   = (state_q == ST_REQ);
    end

endmodule

// File: rtl/epdma_count.sv
module epdma_count #(
    parameter int CNT_W   = 16,
    parameter int BURST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_load,
    input  logic [CNT_W-1:0]   cfg_cnt,
    input  logic               byte_ok,
    input  logic               in_req,
    input  logic [BURST_W-1:0] burst_last,
    output logic [CNT_W-1:0]   cnt_q,
    output logic               burst_done,
    output logic               tc
);

    logic [BURST_W-1:0] bcnt_q;

    assign burst_done = (bcnt_q == burst_last);
    assign tc = (cnt_q == '0) || (byte_ok && (cnt_q == CNT_W'(1)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bcnt_q <= '0;
        end else if (cfg_load || !in_req) begin
            bcnt_q <= '0;
        end else if (byte_ok) begin
            bcnt_q <= burst_done ? '0 : bcnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (cfg_load) begin
            cnt_q <= cfg_cnt;
        end else if (byte_ok && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

endmodule

// File: rtl/epdma_port_mux.sv
module epdma_port_mux #(
    parameter int EP_IDX_W = 4
) (
    input  logic                dack_act,
    input  logic [EP_IDX_W-1:0] dma_ep,
    input  logic [EP_IDX_W-1:0] io_ptr,
    input  logic                byte_ok,
    input  logic                dir,
    input  logic                io_rd,
    input  logic                io_wr,
    output logic [EP_IDX_W-1:0] port_ep,
    output logic                port_dma,
    output logic                buf_rd,
    output logic                buf_wr
);

    always_comb begin
        if (dack_act) begin
            port_ep  = dma_ep;
            port_dma = 1'b1;
            buf_rd   = byte_ok && !dir;
            buf_wr   = byte_ok && dir;
        end else begin
            port_ep  = io_ptr;
            port_dma = 1'b0;
            buf_rd   = io_rd;
            buf_wr   = io_wr;
        end
    end

endmodule

// File: rtl/epdma_hs_ctrl.sv
module epdma_hs_ctrl
    import epdma_pkg::*;
#(
    parameter int EP_IDX_W = 4,
    parameter int CNT_W    = 16,
    parameter int BURST_W  = 4,
    localparam int NUM_EP  = 1 << EP_IDX_W
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [EP_IDX_W-1:0] cfg_ep,
    input  logic                cfg_burst,
    input  logic [BURST_W-1:0]  cfg_blen,
    input  logic [CNT_W-1:0]    cfg_cnt,
    input  logic                cfg_en,
    input  logic                cfg_dack_only,
    input  logic                cfg_dreq_pol,
    input  logic                cfg_dack_pol,
    input  logic                cfg_eot_pol,
    input  logic                eot_clr,
    input  logic                io_ptr_we,
    input  logic [EP_IDX_W-1:0] io_ptr_d,
    input  logic                io_rd,
    input  logic                io_wr,
    input  logic [NUM_EP-1:0]   ep_valid,
    input  logic [NUM_EP-1:0]   ep_dir,
    input  logic [NUM_EP-1:0]   ep_ready,
    input  logic                short_pkt,
    input  logic                dack_pin,
    input  logic                eot_pin,
    output logic                dreq_pin,
    output logic [EP_IDX_W-1:0] port_ep,
    output logic                port_dma,
    output logic                buf_rd,
    output logic                buf_wr,
    output logic                dma_dir,
    output logic                dma_en,
    output logic                eot_flag,
    output logic [CNT_W-1:0]    xfer_left
);

    // configuration state
    logic [EP_IDX_W-1:0] ep_q;
    logic [EP_IDX_W-1:0] io_ptr_q;
    logic [BURST_W-1:0]  blen_q;
    logic                burst_q;
    logic                donly_q;
    logic                dreq_pol_q;
    logic                dack_pol_q;
    logic                eot_pol_q;
    logic                en_q;
    logic                flag_q;

    // internal wires
    dma_state_e          state_q;
    logic                dreq_act;
    logic                in_req;
    logic                dack_act;
    logic                ext_eot;
    logic                ep_ok;
    logic                byte_ok;
    logic                burst_done;
    logic                tc;
    logic                eot_evt;
    logic [BURST_W-1:0]  burst_last;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ep_q       <= '0;
            blen_q     <= '0;
            burst_q    <= 1'b0;
            donly_q    <= 1'b1;
            dreq_pol_q <= 1'b1;
            dack_pol_q <= 1'b1;
            eot_pol_q  <= 1'b1;
        end else if (cfg_we) begin
            ep_q       <= cfg_ep;
            blen_q     <= cfg_blen;
            burst_q    <= cfg_burst;
            donly_q    <= cfg_dack_only;
            dreq_pol_q <= cfg_dreq_pol;
            dack_pol_q <= cfg_dack_pol;
            eot_pol_q  <= cfg_eot_pol;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         io_ptr_q <= '0;
        else if (io_ptr_we) io_ptr_q <= io_ptr_d;
    end

    assign dack_act   = (dack_pin == dack_pol_q);
    assign ext_eot    = (eot_pin == eot_pol_q);
    assign dma_dir    = ep_dir[ep_q];
    assign ep_ok      = ep_valid[ep_q] && ep_ready[ep_q];
    assign burst_last = burst_q ? blen_q : '0;
    assign byte_ok    = in_req && dack_act &&
                        (donly_q || (dma_dir ? io_wr : io_rd));
    assign eot_evt    = en_q && !cfg_we && (tc || ext_eot || short_pkt);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       en_q <= 1'b0;
        else if (cfg_we)  en_q <= cfg_en;
        else if (eot_evt) en_q <= 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       flag_q <= 1'b0;
        else if (eot_evt) flag_q <= 1'b1;
        else if (eot_clr) flag_q <= 1'b0;
    end

    epdma_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_we),
        .cfg_en     (cfg_en),
        .en_q       (en_q),
        .ep_ok      (ep_ok),
        .eot_evt    (eot_evt),
        .byte_ok    (byte_ok),
        .burst_done (burst_done),
        .state_q    (state_q),
        .dreq_act   (dreq_act),
        .in_req     (in_req)
    );

    epdma_count #(.CNT_W(CNT_W), .BURST_W(BURST_W)) u_count (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_load   (cfg_we),
        .cfg_cnt    (cfg_cnt),
        .byte_ok    (byte_ok),
        .in_req     (in_req),
        .burst_last (burst_last),
        .cnt_q      (xfer_left),
        .burst_done (burst_done),
        .tc         (tc)
    );

    epdma_port_mux #(.EP_IDX_W(EP_IDX_W)) u_mux (
        .dack_act (dack_act),
        .dma_ep   (ep_q),
        .io_ptr   (io_ptr_q),
        .byte_ok  (byte_ok),
        .dir      (dma_dir),
        .io_rd    (io_rd),
        .io_wr    (io_wr),
        .port_ep  (port_ep),
        .port_dma (port_dma),
        .buf_rd   (buf_rd),
        .buf_wr   (buf_wr)
    );

    assign dreq_pin = (dreq_act == dreq_pol_q);
    assign dma_en   = en_q;
    assign eot_flag = flag_q;

endmodule

// File: rtl/epdma_chk.sv
module epdma_chk #(
    parameter int EP_IDX_W = 4,
    parameter int CNT_W    = 16
) (
    input logic                clk,
    input logic                rst_n,
    input logic                dreq_act,
    input logic                dma_en,
    input logic                ep_ok,
    input logic                io_ptr_we,
    input logic [EP_IDX_W-1:0] io_ptr_q,
    input logic                dack_act,
    input logic                port_dma,
    input logic [EP_IDX_W-1:0] port_ep,
    input logic [EP_IDX_W-1:0] ep_q,
    input logic                byte_ok,
    input logic                burst_q,
    input logic                cfg_we,
    input logic [CNT_W-1:0]    xfer_left,
    input logic                eot_flag,
    input logic                eot_clr,
    input logic                buf_rd,
    input logic                buf_wr,
    input logic                dma_dir
);

    // R2
    ep_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!dreq_act && !ep_ok) |=> !dreq_act);

    // R2
    req_needs_en_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dreq_act |-> dma_en);

    // R3
    dir_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_wr && dack_act) |-> dma_dir);

    // R3
    dir_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (buf_rd && dack_act) |-> !dma_dir);

    // R4
    io_ptr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !io_ptr_we |=> $stable(io_ptr_q));

    // R4
    dack_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dack_act |-> (port_dma && (port_ep == ep_q)));

    // R5
    single_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && !burst_q && !cfg_we) |=> !dreq_act);

    // R7
    count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && !cfg_we && (xfer_left != '0)) |=>
            (xfer_left == $past(xfer_left) - 1'b1));

    // R7
    tc_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_ok && !cfg_we && (xfer_left == CNT_W'(1))) |=>
            (!dma_en && eot_flag && !dreq_act));

    // R11
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eot_flag && !eot_clr) |=> eot_flag);

endmodule

bind epdma_hs_ctrl epdma_chk #(.EP_IDX_W(EP_IDX_W), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dreq_act  (dreq_act),
    .dma_en    (dma_en),
    .ep_ok     (ep_ok),
    .io_ptr_we (io_ptr_we),
    .io_ptr_q  (io_ptr_q),
    .dack_act  (dack_act),
    .port_dma  (port_dma),
    .port_ep   (port_ep),
    .ep_q      (ep_q),
    .byte_ok   (byte_ok),
    .burst_q   (burst_q),
    .cfg_we    (cfg_we),
    .xfer_left (xfer_left),
    .eot_flag  (eot_flag),
    .eot_clr   (eot_clr),
    .buf_rd    (buf_rd),
    .buf_wr    (buf_wr),
    .dma_dir   (dma_dir)
);

// File: tb/tb_epdma_hs_ctrl.sv
module tb_epdma_hs_ctrl;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_ep = '0;
    logic        cfg_burst = 1'b0;
    logic [3:0]  cfg_blen = '0;
    logic [15:0] cfg_cnt = '0;
    logic        cfg_en = 1'b0;
    logic        cfg_dack_only = 1'b1;
    logic        cfg_dreq_pol = 1'b1;
    logic        cfg_dack_pol = 1'b1;
    logic        cfg_eot_pol = 1'b1;
    logic        eot_clr = 1'b0;
    logic        io_ptr_we = 1'b0;
    logic [3:0]  io_ptr_d = '0;
    logic        io_rd = 1'b0;
    logic        io_wr = 1'b0;
    logic [15:0] ep_valid = 16'hFFFC;
    logic [15:0] ep_dir = 16'hAAAA;
    logic [15:0] ep_ready = 16'hFFFF;
    logic        short_pkt = 1'b0;
    logic        dack_pin = 1'b0;
    logic        eot_pin = 1'b0;
    logic        dreq_pin;
    logic [3:0]  port_ep;
    logic        port_dma;
    logic        buf_rd;
    logic        buf_wr;
    logic        dma_dir;
    logic        dma_en;
    logic        eot_flag;
    logic [15:0] xfer_left;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    epdma_hs_ctrl dut (.*);

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic cfg(input logic [3:0] ep, input logic bst, input logic [3:0] bl,
                       input logic [15:0] cnt, input logic en, input logic donly,
                       input logic rp, input logic kp, input logic tp);
        @(negedge clk);
        cfg_we = 1'b1; cfg_ep = ep; cfg_burst = bst; cfg_blen = bl; cfg_cnt = cnt;
        cfg_en = en; cfg_dack_only = donly;
        cfg_dreq_pol = rp; cfg_dack_pol = kp; cfg_eot_pol = tp;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clear_flag();
        eot_clr = 1'b1;
        @(negedge clk);
        eot_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 dreq", dreq_pin, 0);
        chk("R1 en", dma_en, 0);
        chk("R1 flag", eot_flag, 0);
        chk("R1 count", xfer_left, 0);
        chk("R1 port_ep", port_ep, 0);
        chk("R1 port_dma", port_dma, 0);
    endtask

    task automatic t_single_read();
        cfg(4'd2, 0, 4'd0, 16'd3, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R2 dreq up", dreq_pin, 1);
        chk("R3 dir read", dma_dir, 0);
        dack_pin = 1'b1;
        #1;
        chk("R3 buf_rd", buf_rd, 1);
        chk("R3 buf_wr", buf_wr, 0);
        chk("R4 dma ep", port_ep, 2);
        chk("R4 dma flag", port_dma, 1);
        @(negedge clk);
        dack_pin = 1'b0;
        chk("R5 single drop", dreq_pin, 0);
        chk("R7 count", xfer_left, 2);
        @(negedge clk);
        chk("R5 single rerequest", dreq_pin, 1);
    endtask

    task automatic t_burst_write();
        cfg(4'd3, 1, 4'd3, 16'd10, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R3 dir write", dma_dir, 1);
        dack_pin = 1'b1;
        #1;
        chk("R3 buf_wr", buf_wr, 1);
        repeat (3) @(negedge clk);
        chk("R5 burst holds", dreq_pin, 1);
        @(negedge clk);
        dack_pin = 1'b0;
        chk("R5 burst drop", dreq_pin, 0);
        chk("R7 burst count", xfer_left, 6);
    endtask

    task automatic t_strobe_mode();
        cfg(4'd2, 1, 4'd1, 16'd5, 1, 0, 1, 1, 1);
        @(negedge clk);
        dack_pin = 1'b1;
        #1;
        chk("R6 no strobe rd", buf_rd, 0);
        @(negedge clk);
        chk("R6 no strobe count", xfer_left, 5);
        io_wr = 1'b1;
        @(negedge clk);
        io_wr = 1'b0;
        chk("R6 wrong strobe count", xfer_left, 5);
        io_rd = 1'b1;
        #1;
        chk("R6 strobe rd", buf_rd, 1);
        @(negedge clk);
        io_rd = 1'b0;
        dack_pin = 1'b0;
        chk("R6 strobe count", xfer_left, 4);
        chk("R5 burst not done", dreq_pin, 1);
    endtask

    task automatic t_terminal_count();
        clear_flag();
        cfg(4'd2, 1, 4'd15, 16'd3, 1, 1, 1, 1, 1);
        @(negedge clk);
        dack_pin = 1'b1;
        repeat (3) @(negedge clk);
        dack_pin = 1'b0;
        chk("R7 tc en", dma_en, 0);
        chk("R7 tc flag", eot_flag, 1);
        chk("R7 tc dreq", dreq_pin, 0);
        chk("R7 tc count", xfer_left, 0);
    endtask

    task automatic t_zero_count();
        clear_flag();
        cfg(4'd2, 0, 4'd0, 16'd0, 1, 1, 1, 1, 1);
        chk("R12 no dreq", dreq_pin, 0);
        @(negedge clk);
        chk("R12 en", dma_en, 0);
        chk("R12 flag", eot_flag, 1);
        chk("R12 dreq", dreq_pin, 0);
    endtask

    task automatic t_ext_eot();
        cfg(4'd2, 0, 4'd0, 16'd100, 0, 1, 1, 1, 0);
        eot_pin = 1'b1;
        clear_flag();
        cfg(4'd2, 0, 4'd0, 16'd100, 1, 1, 1, 1, 0);
        @(negedge clk);
        dack_pin = 1'b1;
        @(negedge clk);
        dack_pin = 1'b0;
        @(negedge clk);
        chk("R8 dreq before", dreq_pin, 1);
        chk("R10 eot idle high", eot_flag, 0);
        eot_pin = 1'b0;
        @(negedge clk);
        chk("R8 en", dma_en, 0);
        chk("R8 flag", eot_flag, 1);
        chk("R8 dreq", dreq_pin, 0);
        chk("R8 count", xfer_left, 99);
        eot_pin = 1'b1;
        cfg(4'd2, 0, 4'd0, 16'd0, 0, 1, 1, 1, 1);
        eot_pin = 1'b0;
    endtask

    task automatic t_short();
        clear_flag();
        cfg(4'd2, 0, 4'd0, 16'd50, 1, 1, 1, 1, 1);
        @(negedge clk);
        short_pkt = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0;
        chk("R9 en", dma_en, 0);
        chk("R9 flag", eot_flag, 1);
        chk("R9 dreq", dreq_pin, 0);
        chk("R9 count", xfer_left, 50);
    endtask

    task automatic t_invalid();
        cfg(4'd1, 0, 4'd0, 16'd5, 1, 1, 1, 1, 1);
        repeat (3) @(negedge clk);
        chk("R2 invalid ep dreq", dreq_pin, 0);
        chk("R2 invalid ep en", dma_en, 1);
        ep_ready[2] = 1'b0;
        cfg(4'd2, 0, 4'd0, 16'd5, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R2 not ready", dreq_pin, 0);
        ep_ready[2] = 1'b1;
        @(negedge clk);
        chk("R2 ready", dreq_pin, 1);
    endtask

    task automatic t_polarity();
        cfg(4'd2, 0, 4'd0, 16'd5, 0, 1, 0, 0, 1);
        dack_pin = 1'b1;
        @(negedge clk);
        chk("R10 dreq idle high", dreq_pin, 1);
        cfg(4'd2, 0, 4'd0, 16'd5, 1, 1, 0, 0, 1);
        @(negedge clk);
        chk("R10 dreq active low", dreq_pin, 0);
        dack_pin = 1'b0;
        #1;
        chk("R10 dack active low", buf_rd, 1);
        @(negedge clk);
        dack_pin = 1'b1;
        chk("R10 dreq after byte", dreq_pin, 1);
        chk("R10 count", xfer_left, 4);
        cfg(4'd2, 0, 4'd0, 16'd5, 0, 1, 1, 1, 1);
        dack_pin = 1'b0;
    endtask

    task automatic t_interleave();
        @(negedge clk);
        io_ptr_we = 1'b1; io_ptr_d = 4'd7;
        @(negedge clk);
        io_ptr_we = 1'b0;
        cfg(4'd2, 0, 4'd0, 16'd9, 1, 1, 1, 1, 1);
        @(negedge clk);
        chk("R4 io ptr", port_ep, 7);
        chk("R4 io cycle", port_dma, 0);
        io_rd = 1'b1;
        #1;
        chk("R4 io read", buf_rd, 1);
        @(negedge clk);
        io_rd = 1'b0;
        chk("R4 io no count", xfer_left, 9);
        dack_pin = 1'b1;
        #1;
        chk("R4 dma override", port_ep, 2);
        @(negedge clk);
        dack_pin = 1'b0;
        #1;
        chk("R4 ptr restored", port_ep, 7);
        chk("R4 dma count", xfer_left, 8);
    endtask

    task automatic t_sticky();
        clear_flag();
        chk("R11 cleared", eot_flag, 0);
        cfg(4'd2, 0, 4'd0, 16'd50, 1, 1, 1, 1, 1);
        @(negedge clk);
        short_pkt = 1'b1; eot_clr = 1'b1;
        @(negedge clk);
        short_pkt = 1'b0; eot_clr = 1'b0;
        chk("R11 set wins", eot_flag, 1);
        repeat (3) @(negedge clk);
        chk("R11 sticky", eot_flag, 1);
        clear_flag();
        chk("R11 clear", eot_flag, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single_read();
        t_burst_write();
        t_strobe_mode();
        t_terminal_count();
        t_zero_count();
        t_ext_eot();
        t_short();
        t_invalid();
        t_polarity();
        t_interleave();
        t_sticky();
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 100000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule